// File: doc/BRIEF.md
# Indirectly Addressed Event Counter Bank

This block holds a bank of wide event counters that software reaches through a small window of four control registers. One register holds a per-counter enable flag. A second holds, for every counter, a 2-bit field naming which of four incoming event strobes that counter follows. A third holds the number of the counter that is currently addressed. The fourth is a data window: reading it returns the addressed counter, and writing it loads that counter.

On every clock edge, each enabled counter whose chosen strobe is high advances by one. The strobes come from elsewhere in the chip and are sampled as plain level signals, one count per cycle. Software selects a counter by writing its number to the index register, then reads or loads it through the data window. Only one counter is visible at a time.

Top module: `pctr_bank`

## Requirements
- R1: A synchronous active-high reset clears every counter to zero, and clears the enable, event-select and index registers to zero.
- R2: Register selector codes are 0 for enable, 1 for event-select, 2 for index and 3 for the data window. Reads are combinational from the selector. The enable register reads back as its 32 flags in bits [31:0], with zeros above. A write to one register changes no other register.
- R3: Counter i follows event strobe number k, where k is the value in bits [2i+1:2i] of the event-select register. Strobes other than its own have no effect on it.
- R4: On each rising clock edge, an enabled counter whose selected strobe is high increases by exactly one. A counter whose enable flag is clear keeps its value whatever the strobes do.
- R5: The index register keeps only bits [4:0] of a write and reads back with all higher bits zero.
- R6: The data window reads the counter named by the index register. A write to it loads the full 64-bit write data into that counter only, and leaves every other counter unchanged.
- R7: When a data-window write and an increment hit the same counter in the same cycle, the written value is stored and the increment is lost.
- R8: A counter holding all ones that increments wraps to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr_i | input | 1 | Write strobe for the register window |
| sw_sel_i | input | 2 | Register selector (0 enable, 1 event-select, 2 index, 3 data) |
| sw_wdata_i | input | 64 | Write data |
| sw_rdata_o | output | 64 | Read data of the selected register |
| evt_i | input | 4 | Event strobes, one count per high cycle |

## Verification
The assertions assume that the strobes and the register port hold steady across each rising edge. They also assume that the selector only ever carries its four defined codes, and that reset is held for at least one edge before activity starts. The bench changes every input on the falling edge only and holds the strobes low during register accesses, except in the one case that tests write-versus-increment priority. It sweeps every strobe choice over all 32 counters by rotating the select pattern, so each counter sees each of the four strobes with a distinct expected count.

// File: rtl/pctr_pkg.sv
package pctr_pkg;

    localparam int unsigned PC_NUM_CTRS = 32;
    localparam int unsigned PC_CTR_W    = 64;
    localparam int unsigned PC_NUM_EVT  = 4;
    localparam int unsigned PC_DATA_W   = 64;

    typedef enum logic [1:0] {
        REG_ENABLE = 2'd0,
        REG_EVSEL  = 2'd1,
        REG_INDEX  = 2'd2,
        REG_VALUE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic                 wr;
        reg_sel_e             sel;
        logic [PC_DATA_W-1:0] data;
    } sw_req_t;

    function automatic logic is_write(input sw_req_t r, input reg_sel_e s);
        return r.wr && (r.sel == s);
    endfunction

endpackage

// File: rtl/pctr_ctrl_regs.sv
module pctr_ctrl_regs
    import pctr_pkg::*;
#(
    parameter int unsigned NUM_CTRS = PC_NUM_CTRS,
    parameter int unsigned SEL_W    = 2,
    parameter int unsigned IDX_W    = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  sw_req_t                   req,
    output logic [NUM_CTRS-1:0]       en_q,
    output logic [NUM_CTRS*SEL_W-1:0] evsel_q,
    output logic [IDX_W-1:0]          idx_q,
    output logic                      val_ld
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            evsel_q <= '0;
            idx_q   <= '0;
        end else begin
            if (is_write(req, REG_ENABLE)) en_q    <= req.data[NUM_CTRS-1:0];
            if (is_write(req, REG_EVSEL))  evsel_q <= req.data[NUM_CTRS*SEL_W-1:0];
            if (is_write(req, REG_INDEX))  idx_q   <= req.data[IDX_W-1:0];
        end
    end

    assign val_ld = is_write(req, REG_VALUE);

    // R1
    reset_clears_ctrl_chk: assert property (@(posedge clk)
        rst |=> (en_q == '0 && evsel_q == '0 && idx_q == '0));

    // R2
    ctrl_hold_on_value_wr_chk: assert property (@(posedge clk) disable iff (rst)
        val_ld |=> ($stable(en_q) && $stable(evsel_q) && $stable(idx_q)));

endmodule

// File: rtl/pctr_evt_route.sv
module pctr_evt_route #(
    parameter int unsigned NUM_CTRS = 32,
    parameter int unsigned NUM_EVT  = 4,
    parameter int unsigned SEL_W    = 2
) (
    input  logic [NUM_CTRS-1:0]       en,
    input  logic [NUM_CTRS*SEL_W-1:0] evsel,
    input  logic [NUM_EVT-1:0]        evt,
    output logic [NUM_CTRS-1:0]       inc
);

    for (genvar i = 0; i < NUM_CTRS; i++) begin : g_route
        logic [SEL_W-1:0] pick;
        assign pick   = evsel[SEL_W*i +: SEL_W];
        assign inc[i] = en[i] & evt[pick];
    end

endmodule

// File: rtl/pctr_counter.sv
module pctr_counter #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (ld)  q <= ld_val;
        else if (inc) q <= q + W'(1);
    end

    // R7
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ld |=> q == $past(ld_val));

    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld && inc) |=> q == $past(q) + W'(1));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld && !inc) |=> $stable(q));

    // R8
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld && inc && q == '1) |=> q == '0);

endmodule

// File: rtl/pctr_bank.sv
module pctr_bank
    import pctr_pkg::*;
#(
    parameter int unsigned NUM_CTRS = PC_NUM_CTRS,
    parameter int unsigned CTR_W    = PC_CTR_W,
    parameter int unsigned NUM_EVT  = PC_NUM_EVT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sw_wr_i,
    input  logic [1:0]           sw_sel_i,
    input  logic [PC_DATA_W-1:0] sw_wdata_i,
    output logic [PC_DATA_W-1:0] sw_rdata_o,
    input  logic [NUM_EVT-1:0]   evt_i
);

    localparam int unsigned SEL_W = $clog2(NUM_EVT);
    localparam int unsigned IDX_W = $clog2(NUM_CTRS);

    sw_req_t                   req;
    logic [NUM_CTRS-1:0]       en_q;
    logic [NUM_CTRS*SEL_W-1:0] evsel_q;
    logic [IDX_W-1:0]          idx_q;
    logic                      val_ld;
    logic [NUM_CTRS-1:0]       inc;
    logic [CTR_W-1:0]          ctr_q [NUM_CTRS];

    assign req.wr   = sw_wr_i;
    assign req.sel  = reg_sel_e'(sw_sel_i);
    assign req.data = sw_wdata_i;

    pctr_ctrl_regs #(
        .NUM_CTRS (NUM_CTRS),
        .SEL_W    (SEL_W),
        .IDX_W    (IDX_W)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .en_q    (en_q),
        .evsel_q (evsel_q),
        .idx_q   (idx_q),
        .val_ld  (val_ld)
    );

    pctr_evt_route #(
        .NUM_CTRS (NUM_CTRS),
        .NUM_EVT  (NUM_EVT),
        .SEL_W    (SEL_W)
    ) u_route (
        .en    (en_q),
        .evsel (evsel_q),
        .evt   (evt_i),
        .inc   (inc)
    );

    for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ctr
        logic ld_here;
        assign ld_here = val_ld && (idx_q == IDX_W'(i));

        pctr_counter #(.W(CTR_W)) u_ctr (
            .clk    (clk),
            .rst    (rst),
            .ld     (ld_here),
            .ld_val (sw_wdata_i[CTR_W-1:0]),
            .inc    (inc[i]),
            .q      (ctr_q[i])
        );
    end

    always_comb begin
        unique case (req.sel)
            REG_ENABLE: sw_rdata_o = PC_DATA_W'(en_q);
            REG_EVSEL:  sw_rdata_o = PC_DATA_W'(evsel_q);
            REG_INDEX:  sw_rdata_o = PC_DATA_W'(idx_q);
            default:    sw_rdata_o = PC_DATA_W'(ctr_q[idx_q]);
        endcase
    end

    // R5
    index_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_sel_i == 2'd2) |-> sw_rdata_o[PC_DATA_W-1:IDX_W] == '0);

    // R6
    window_load_chk: assert property (@(posedge clk) disable iff (rst)
        val_ld |=> ctr_q[$past(idx_q)] == $past(sw_wdata_i[CTR_W-1:0]));

    // R1
    reset_clears_ctr_chk: assert property (@(posedge clk)
        rst |=> (ctr_q[0] == '0 && ctr_q[NUM_CTRS-1] == '0));

endmodule

// File: tb/pctr_bank_tb_top.sv
module pctr_bank_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_wr = 1'b0;
    logic [1:0]  sw_sel = 2'd0;
    logic [63:0] sw_wdata = '0;
    logic [63:0] sw_rdata;
    logic [3:0]  evt = 4'h0;

    int n_chk  = 0;
    int n_fail = 0;

    logic [63:0] exp_c [32];
    logic [31:0] en_m;
    logic [63:0] sel_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    pctr_bank dut_i (
        .clk        (clk),
        .rst        (rst),
        .sw_wr_i    (sw_wr),
        .sw_sel_i   (sw_sel),
        .sw_wdata_i (sw_wdata),
        .sw_rdata_o (sw_rdata),
        .evt_i      (evt)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        @(negedge clk);
        sw_wr = 1'b1; sw_sel = a; sw_wdata = d;
        @(negedge clk);
        sw_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] v);
        @(negedge clk);
        sw_sel = a;
        #1 v = sw_rdata;
    endtask

    task automatic rd_ctr(input int k, output logic [63:0] v);
        wr(2'd2, 64'(k));
        rd(2'd3, v);
    endtask

    task automatic model_add(input logic [3:0] m, input int n);
        for (int i = 0; i < 32; i++)
            if (en_m[i] && m[sel_m[2*i +: 2]]) exp_c[i] = exp_c[i] + 64'(n);
    endtask

    task automatic pulse(input logic [3:0] m, input int n);
        @(negedge clk);
        evt = m;
        repeat (n) @(negedge clk);
        evt = 4'h0;
        model_add(m, n);
    endtask

    task automatic check_all(input string req);
        logic [63:0] v;
        for (int i = 0; i < 32; i++) begin
            rd_ctr(i, v);
            chk(req, v, exp_c[i]);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [63:0] v;
        for (int i = 0; i < 32; i++) exp_c[i] = '0;
        en_m = '0; sel_m = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: control registers and counters clear after reset
        rd(2'd0, v); chk("R1 enable", v, 64'h0);
        rd(2'd1, v); chk("R1 evsel", v, 64'h0);
        rd(2'd2, v); chk("R1 index", v, 64'h0);
        check_all("R1 counter");

        // R4: strobes with every counter disabled change nothing
        pulse(4'hF, 3);
        check_all("R4 disabled hold");

        // R2: enable read-back zero-extended, write does not disturb others
        en_m = 32'hFFFF_FFFF;
        wr(2'd0, 64'hABCD_0000_FFFF_FFFF);
        rd(2'd0, v); chk("R2 enable readback", v, 64'h0000_0000_FFFF_FFFF);
        rd(2'd1, v); chk("R2 evsel untouched", v, 64'h0);

        // R3 R4: rotate selectors so each counter follows each strobe
        for (int rot = 0; rot < 4; rot++) begin
            for (int i = 0; i < 32; i++) sel_m[2*i +: 2] = 2'((i + rot) % 4);
            wr(2'd1, sel_m);
            rd(2'd1, v); chk("R3 evsel readback", v, sel_m);
            for (int e = 0; e < 4; e++) pulse(4'(1 << e), e + 1);
            check_all("R3 selected strobe count");
        end

        // R4: alternate counters disabled, combined strobes
        en_m = 32'h5555_5555;
        wr(2'd0, 64'(en_m));
        pulse(4'hF, 2);
        pulse(4'h6, 3);
        check_all("R4 partial enable");

        // R5: index keeps only low five bits
        wr(2'd2, 64'hFFFF_FFFF_FFFF_FFE7);
        rd(2'd2, v); chk("R5 index truncation", v, 64'h7);

        // R6: window load hits only the indexed counter
        wr(2'd2, 64'd5);
        wr(2'd3, 64'h1234_5678_9ABC_DEF0);
        exp_c[5] = 64'h1234_5678_9ABC_DEF0;
        check_all("R6 window load");

        // R8: wrap from all ones to zero
        en_m = 32'hFFFF_FFFF;
        wr(2'd0, 64'(en_m));
        wr(2'd2, 64'd3);
        wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        exp_c[3] = 64'hFFFF_FFFF_FFFF_FFFF;
        pulse(4'hF, 1);
        rd_ctr(3, v); chk("R8 wrap", v, 64'h0);
        check_all("R8 others after wrap");

        // R7: load and increment collide on counter 9
        wr(2'd2, 64'd9);
        @(negedge clk);
        evt = 4'hF; sw_wr = 1'b1; sw_sel = 2'd3; sw_wdata = 64'hCAFE_0000_0000_0042;
        @(negedge clk);
        evt = 4'h0; sw_wr = 1'b0;
        model_add(4'hF, 1);
        exp_c[9] = 64'hCAFE_0000_0000_0042;
        rd(2'd3, v); chk("R7 load beats increment", v, 64'hCAFE_0000_0000_0042);
        check_all("R7 neighbours still count");

        report();
    end

endmodule